// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reprograms one PLL and reports the outcome. A request carries a target output rate in hertz. The block rounds that rate to the closest entry of a constant rate table and packs that entry's divider and band codes into a PLL control word. It applies the word with power-down and bypass cleared, then waits a fixed lock interval before it samples the PLL status bits. It finishes with a one-cycle done pulse and a result code.

When the block is built for the core PLL, it also drives the select for the divider of the core's interface clock. Above a rate threshold the select moves to divide-by-2 before the new word is applied. At or below the threshold it moves back to divide-by-1, and only once the PLL has locked without error. A combinational read path always gives the output rate that the present control word implies.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is held and after it is released, `ctrl_o` equals `RESET_CTRL` (default 0x1, power-down set), `if_div_o`, `busy_o` and `done_o` are 0, and `err_code_o` is 0.
- R2: The request rate is matched to the table entry whose rate is closest by absolute difference. On equal distance the lower index wins. The scan stops at the first entry whose rate is zero, so entries after it are never chosen.
- R3: The applied control word holds the output divider code in bits 3:2, the input divider code in bits 8:4, the feedback divider code in bits 15:9 and the band code in bits 31:20. Bits 1:0 and 19:16 are zero.
- R4: A request is taken on a clock edge while `busy_o` is 0. `if_div_o` may change on the edge after it, and `ctrl_o` changes on the second edge after it. `done_o` is 1 for exactly one cycle, beginning `LOCK_US*CYC_PER_US+3` edges after the accepting edge. Lock and error status are sampled on that same edge.
- R5: If the lock status is 0 when sampled, `err_code_o` becomes 1 (timeout).
- R6: If the lock status is 1 and the error status is 1, `err_code_o` becomes 2 (invalid configuration). If lock is 1 and error is 0, it becomes 0. It changes only together with `done_o`.
- R7: In the core variant, when the chosen table rate exceeds `THRESH_HZ`, `if_div_o` is set to 1 one cycle before the control word is applied.
- R8: In the core variant, when the chosen rate is at or below `THRESH_HZ`, `if_div_o` is cleared to 0 with `done_o`, and only if the result code is 0. Otherwise it keeps its value.
- R9: `rate_rd_o` = `PARENT_HZ`·2·(fb+1) / ((in+1)·2^out), truncated, where the codes are taken from the fields of `ctrl_o`.
- R10: `rate_rd_o` equals `PARENT_HZ` when bit 1 (bypass) of `ctrl_o` is set, whatever bit 0 holds. It is 0 when only bit 0 (power-down) is set.
- R11: A request raised while `busy_o` is 1 is ignored. It does not change the word being applied and produces no extra done pulse.
- R12: In the non-core variant `if_div_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a reprogramming when idle |
| rate_i | input | 32 | Requested rate in Hz |
| lock_i | input | 1 | PLL lock status bit |
| pll_err_i | input | 1 | PLL error status bit |
| ctrl_o | output | 32 | PLL control word |
| if_div_o | output | 1 | Interface divider select: 0 divide-by-1, 1 divide-by-2 |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 2 | 0 ok, 1 timeout, 2 invalid configuration |
| rate_rd_o | output | 32 | Rate implied by the current control word |

## Verification
The assertions check ordering rules on every cycle. The control word changes only while busy, and only with power-down and bypass clear. The divider select rises only mid-sequence and falls only with a successful done. The result code moves only on done, a timeout code needs the lock bit to have been low, and done never lasts two cycles. Rate rounding with ties and the terminator, the exact lock-wait latency, the field packing and the readback arithmetic can only be shown by the bench's scenarios, since they depend on table contents and on request values.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int RATE_W  = 32;
  localparam int CTRL_W  = 32;
  localparam int OUT_W   = 2;
  localparam int IN_W    = 5;
  localparam int FB_W    = 7;
  localparam int OUT_LSB = 2;
  localparam int IN_LSB  = 4;
  localparam int FB_LSB  = 9;
  localparam int BAND_LSB = 20;
  localparam int BAND_W  = CTRL_W - BAND_LSB;
  localparam int PD_BIT  = 0;
  localparam int BYP_BIT = 1;
  localparam int TBL_N   = 9;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [IN_W-1:0]   in_code;
    logic [FB_W-1:0]   fb_code;
    logic [OUT_W-1:0]  out_code;
    logic [BAND_W-1:0] band;
  } rate_entry_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_BADCFG  = 2'd2
  } seq_res_e;

  // zero rate terminates the scan
  localparam rate_entry_t DEF_TABLE [TBL_N] = '{
    '{32'd100_000_000,  5'd0, 7'd11, 2'd3, 12'd0},
    '{32'd200_000_000,  5'd1, 7'd47, 2'd3, 12'd0},
    '{32'd300_000_000,  5'd1, 7'd35, 2'd2, 12'd0},
    '{32'd400_000_000,  5'd1, 7'd47, 2'd2, 12'd0},
    '{32'd500_000_000,  5'd0, 7'd14, 2'd1, 12'd0},
    '{32'd600_000_000,  5'd0, 7'd17, 2'd1, 12'd0},
    '{32'd800_000_000,  5'd0, 7'd23, 2'd1, 12'd0},
    '{32'd1_000_000_000, 5'd1, 7'd29, 2'd0, 12'd0},
    '{32'd0,            5'd0, 7'd0,  2'd0, 12'd0}
  };

  function automatic logic [CTRL_W-1:0] pack_ctrl(rate_entry_t e);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[OUT_LSB +: OUT_W]   = e.out_code;
    w[IN_LSB +: IN_W]     = e.in_code;
    w[FB_LSB +: FB_W]     = e.fb_code;
    w[BAND_LSB +: BAND_W] = e.band;
    return w;
  endfunction
endpackage

// File: rtl/pll_rate_pick.sv
module pll_rate_pick
  import pll_seq_pkg::*;
#(
  parameter rate_entry_t TABLE [TBL_N] = DEF_TABLE
) (
  input  logic [RATE_W-1:0] rate_i,
  output rate_entry_t       pick_o
);
  function automatic logic [RATE_W-1:0] abs_diff(logic [RATE_W-1:0] a, logic [RATE_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [RATE_W-1:0] best_d;
  logic [RATE_W-1:0] cand_d;
  logic              stop;

  always_comb begin
    pick_o = TABLE[0];
    best_d = abs_diff(rate_i, TABLE[0].rate);
    cand_d = '0;
    stop   = 1'b0;
    for (int i = 1; i < TBL_N; i++) begin
      if (TABLE[i].rate == '0) stop = 1'b1;
      if (!stop) begin
        cand_d = abs_diff(rate_i, TABLE[i].rate);
        // strict compare keeps the earlier entry on a tie
        if (cand_d < best_d) begin
          best_d = cand_d;
          pick_o = TABLE[i];
        end
      end
    end
  end
endmodule

// File: rtl/pll_rate_readback.sv
module pll_rate_readback
  import pll_seq_pkg::*;
#(
  parameter logic [RATE_W-1:0] PARENT_HZ = 32'd33_333_333
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [RATE_W-1:0] rate_o
);
  localparam int PROD_W = RATE_W + FB_W + 2;
  localparam int DEN_W  = IN_W + 1 + (1 << OUT_W);

  logic [PROD_W-1:0] num;
  logic [DEN_W-1:0]  den;
  logic [PROD_W-1:0] quo;
  logic              unused_hi;

  assign unused_hi = ^ctrl_i[CTRL_W-1:FB_LSB+FB_W];

  always_comb begin
    num = PROD_W'(PARENT_HZ) * (PROD_W'(ctrl_i[FB_LSB +: FB_W]) + PROD_W'(1)) * PROD_W'(2);
    den = (DEN_W'(ctrl_i[IN_LSB +: IN_W]) + DEN_W'(1)) << ctrl_i[OUT_LSB +: OUT_W];
    quo = num / PROD_W'(den);
    if (ctrl_i[BYP_BIT])      rate_o = PARENT_HZ;
    else if (ctrl_i[PD_BIT])  rate_o = '0;
    else                      rate_o = quo[RATE_W-1:0];
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter bit                CORE_PLL   = 1'b1,
  parameter logic [RATE_W-1:0] THRESH_HZ  = 32'd500_000_000,
  parameter int unsigned       LOCK_CYC   = 20000,
  parameter logic [CTRL_W-1:0] RESET_CTRL = 32'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  rate_entry_t       pick_i,
  input  logic              lock_i,
  input  logic              pll_err_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              if_div_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_code_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_PREDIV, S_WRITE, S_WAIT, S_CHECK} st_e;

  st_e          st_q;
  rate_entry_t  ent_q;
  logic [CNT_W-1:0] cnt_q;
  seq_res_e     res_q;
  logic         above;

  assign above      = ent_q.rate > THRESH_HZ;
  assign busy_o     = (st_q != S_IDLE);
  assign err_code_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ent_q    <= '0;
      cnt_q    <= '0;
      res_q    <= RES_OK;
      ctrl_o   <= RESET_CTRL;
      if_div_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          ent_q <= pick_i;
          st_q  <= S_PREDIV;
        end
        S_PREDIV: begin
          if (CORE_PLL && above) if_div_o <= 1'b1;
          st_q <= S_WRITE;
        end
        S_WRITE: begin
          ctrl_o <= pack_ctrl(ent_q);
          cnt_q  <= '0;
          st_q   <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt_q == CNT_LAST) st_q <= S_CHECK;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        S_CHECK: begin
          done_o <= 1'b1;
          st_q   <= S_IDLE;
          if (!lock_i)        res_q <= RES_TIMEOUT;
          else if (pll_err_i) res_q <= RES_BADCFG;
          else begin
            res_q <= RES_OK;
            if (CORE_PLL && !above) if_div_o <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r3_clean_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> (ctrl_o[BYP_BIT] == 1'b0 && ctrl_o[PD_BIT] == 1'b0));
  a_r11_write_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> busy_o);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_code_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_code_o) |-> done_o);
  a_r5_timeout_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && err_code_o == RES_TIMEOUT |-> !$past(lock_i));
  a_r7_div_up_midseq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(if_div_o) |-> busy_o && !done_o);
  a_r8_div_down_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(if_div_o) |-> done_o && err_code_o == RES_OK);
  a_r12_plain_no_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !CORE_PLL |-> !if_div_o);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter bit                CORE_PLL   = 1'b1,
  parameter logic [RATE_W-1:0] PARENT_HZ  = 32'd33_333_333,
  parameter logic [RATE_W-1:0] THRESH_HZ  = 32'd500_000_000,
  parameter int unsigned       LOCK_US    = 100,
  parameter int unsigned       CYC_PER_US = 200,
  parameter logic [CTRL_W-1:0] RESET_CTRL = 32'h1,
  parameter rate_entry_t       TABLE [TBL_N] = DEF_TABLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              lock_i,
  input  logic              pll_err_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              if_div_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_code_o,
  output logic [RATE_W-1:0] rate_rd_o
);
  localparam int unsigned LOCK_CYC = LOCK_US * CYC_PER_US;

  rate_entry_t pick;

  pll_rate_pick #(.TABLE(TABLE)) u_pick (
    .rate_i (rate_i),
    .pick_o (pick)
  );

  pll_seq_ctrl #(
    .CORE_PLL   (CORE_PLL),
    .THRESH_HZ  (THRESH_HZ),
    .LOCK_CYC   (LOCK_CYC),
    .RESET_CTRL (RESET_CTRL)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .pick_i     (pick),
    .lock_i     (lock_i),
    .pll_err_i  (pll_err_i),
    .ctrl_o     (ctrl_o),
    .if_div_o   (if_div_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_code_o (err_code_o)
  );

  pll_rate_readback #(.PARENT_HZ(PARENT_HZ)) u_rd (
    .ctrl_i (ctrl_o),
    .rate_o (rate_rd_o)
  );

  a_r10_bypass_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BYP_BIT] |-> rate_rd_o == PARENT_HZ);
  a_r10_pd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[PD_BIT] && !ctrl_o[BYP_BIT]) |-> rate_rd_o == '0);
endmodule

// File: tb/pll_reprog_seq_test.sv
`timescale 1ns/1ps
module pll_reprog_seq_test;
  import pll_seq_pkg::*;

  localparam int unsigned LUS = 100;
  localparam int unsigned CPU = 1;
  localparam int LAT = LUS * CPU + 4;   // posedges counted with accepting edge as 1
  localparam longint PARENT = 33_333_333;
  localparam longint THR = 500_000_000;

  localparam rate_entry_t TB_TABLE [TBL_N] = '{
    '{32'd100_000_000,  5'd0, 7'd11, 2'd3, 12'd0},
    '{32'd200_000_000,  5'd1, 7'd47, 2'd3, 12'd0},
    '{32'd300_000_000,  5'd1, 7'd35, 2'd2, 12'd0},
    '{32'd500_000_000,  5'd0, 7'd14, 2'd1, 12'd0},
    '{32'd600_000_000,  5'd0, 7'd17, 2'd1, 12'd2},
    '{32'd800_000_000,  5'd0, 7'd23, 2'd1, 12'd1},
    '{32'd1_000_000_000, 5'd1, 7'd29, 2'd0, 12'd3},
    '{32'd0,            5'd0, 7'd0,  2'd0, 12'd0},
    '{32'd1_600_000_000, 5'd1, 7'd47, 2'd0, 12'd5}
  };

  typedef struct packed {
    logic [31:0] rate;
    logic        lock;
    logic        err;
    logic [3:0]  idx;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'd100_000_000,   1'b1, 1'b0, 4'd0, 2'd0},
    '{32'd149_999_999,   1'b1, 1'b0, 4'd0, 2'd0},
    '{32'd150_000_000,   1'b1, 1'b0, 4'd0, 2'd0},
    '{32'd150_000_001,   1'b1, 1'b0, 4'd1, 2'd0},
    '{32'd550_000_000,   1'b1, 1'b0, 4'd3, 2'd0},
    '{32'd700_000_000,   1'b1, 1'b0, 4'd4, 2'd0},
    '{32'd2_000_000_000, 1'b1, 1'b0, 4'd6, 2'd0},
    '{32'd0,             1'b1, 1'b0, 4'd0, 2'd0},
    '{32'd600_000_000,   1'b0, 1'b0, 4'd4, 2'd1},
    '{32'd300_000_000,   1'b1, 1'b1, 4'd2, 2'd2},
    '{32'd300_000_000,   1'b1, 1'b0, 4'd2, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] rate = '0;
  logic        lock = 1'b0;
  logic        perr = 1'b0;
  logic [31:0] ctrl, ctrl_p, rd, rd_p;
  logic        ifd, ifd_p, busy, busy_p, done, done_p;
  logic [1:0]  code, code_p;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pll_reprog_seq #(
    .CORE_PLL(1'b1), .LOCK_US(LUS), .CYC_PER_US(CPU), .TABLE(TB_TABLE)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rate_i(rate), .lock_i(lock),
    .pll_err_i(perr), .ctrl_o(ctrl), .if_div_o(ifd), .busy_o(busy), .done_o(done),
    .err_code_o(code), .rate_rd_o(rd)
  );

  pll_reprog_seq #(
    .CORE_PLL(1'b0), .LOCK_US(LUS), .CYC_PER_US(CPU), .RESET_CTRL(32'h3), .TABLE(TB_TABLE)
  ) uut_plain (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rate_i(rate), .lock_i(lock),
    .pll_err_i(perr), .ctrl_o(ctrl_p), .if_div_o(ifd_p), .busy_o(busy_p), .done_o(done_p),
    .err_code_o(code_p), .rate_rd_o(rd_p)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint word_of(input int idx);
    rate_entry_t e = TB_TABLE[idx];
    return (longint'(e.out_code) << 2) | (longint'(e.in_code) << 4) |
           (longint'(e.fb_code) << 9) | (longint'(e.band) << 20);
  endfunction

  function automatic longint rate_of(input int idx);
    rate_entry_t e = TB_TABLE[idx];
    return (PARENT * 2 * (longint'(e.fb_code) + 1)) /
           ((longint'(e.in_code) + 1) * (longint'(1) << e.out_code));
  endfunction

  bit if_model = 1'b0;

  task automatic do_op(input vec_t v);
    longint prev_ctrl;
    bit prev_if, high, got;
    int n;
    @(negedge clk);
    rate = v.rate; lock = v.lock; perr = v.err; req = 1'b1;
    prev_ctrl = longint'(ctrl);
    prev_if = ifd;
    high = longint'(TB_TABLE[v.idx].rate) > THR;
    n = 0; got = 1'b0;
    while (!got && n < LAT + 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req = 1'b0;
      if (n == 2) begin
        chk("R7 div select before write", longint'(ifd), longint'(high ? 1'b1 : prev_if));
        chk("R7 word not yet applied", longint'(ctrl), prev_ctrl);
      end
      if (n == 3) chk("R2/R3 applied word", longint'(ctrl), word_of(v.idx));
      if (done) got = 1'b1;
    end
    if (high) if_model = 1'b1;
    else if (v.code == 2'd0) if_model = 1'b0;
    chk("R4 done latency", longint'(n), longint'(LAT));
    chk("R5/R6 result code", longint'(code), longint'(v.code));
    chk("R8 final div select", longint'(ifd), longint'(if_model));
    chk("R9 readback rate", longint'(rd), rate_of(v.idx));
    chk("R12 plain div select", longint'(ifd_p), 0);
    chk("R3 plain word", longint'(ctrl_p), word_of(v.idx));
    @(negedge clk);
    chk("R4 done one cycle", longint'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dones;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 ctrl in reset", longint'(ctrl), 1);
    chk("R1 busy in reset", longint'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl after reset", longint'(ctrl), 1);
    chk("R1 div select", longint'(ifd), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 code", longint'(code), 0);
    chk("R10 power-down readback", longint'(rd), 0);
    chk("R10 bypass over power-down", longint'(rd_p), PARENT);

    for (int k = 0; k < NV; k++) do_op(VECS[k]);

    // R11: second request during busy is dropped
    @(negedge clk);
    rate = 32'd100_000_000; lock = 1'b1; perr = 1'b0; req = 1'b1;
    dones = 0; n = 0;
    while (n < 2 * LAT + 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req = 1'b0;
      if (n == 5) begin
        chk("R11 busy mid sequence", longint'(busy), 1);
        rate = 32'd1_000_000_000; req = 1'b1;
      end
      if (done) dones++;
      if (n == LAT) chk("R11 word from first request", longint'(ctrl), word_of(0));
    end
    chk("R11 single done pulse", longint'(dones), 1);
    chk("R11 word kept", longint'(ctrl), word_of(0));
    chk("R11 div select kept", longint'(ifd), 0);
    chk("R11 idle after", longint'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule